// File: doc/BRIEF.md
# DMA Channel Register Front End with Per-Region Ownership Filtering

This block is the register-access side of a DMA channel controller. It holds the per-channel event, enable and interrupt state, and it exposes that state to software through one memory-mapped slave port. The same register layout can be reached at two kinds of address. One global window gives full access. Four region windows, one per region, give filtered access. Each region has a DMA ownership mask and a QDMA ownership mask. Any access through a region window is ANDed bit by bit with that region's mask. A task or core given one region window can therefore read and change only the channels it owns, while supervisor code uses the global window.

Hardware inputs feed the state. Event pulses set event bits, and transfer-completion pulses set interrupt-pending bits. The block drives out the event, enable and QDMA-enable vectors and a registered interrupt level. An evaluate write in the global window produces a one-cycle request to re-raise the completion interrupt.

Top module: `dma_region_filter`

## Requirements
- R1: After synchronous reset, all channel state, all ownership masks, `rdata`, `irq_level` and `eval_pulse` are zero.
- R2: The global window starts at byte 0x1000. Within any window the mapped word offsets are:
  - event 0x00, event-clear 0x08, event-set 0x10
  - enable 0x20, enable-clear 0x28, enable-set 0x30
  - interrupt-enable 0x50, its clear 0x58, its set 0x60
  - pending 0x68, pending-clear 0x70
  - evaluate 0x78
  - QDMA enable 0x84, its clear 0x88, its set 0x8C

  Global accesses are never masked. `rdata` carries the read value in the cycle after `rd_en` is sampled, and is zero in the cycle after a cycle without `rd_en`.
- R3: Region r's window starts at 0x2000 + 0x200·r, for r from 0 to 3. A write through it to a DMA-side set or clear register acts only on bits whose DMA mask bit is 1. All other bits keep their value.
- R4: A read of event, enable, interrupt-enable or pending through a region window returns the register value ANDed with that region's DMA mask.
- R5: QDMA enable set, clear and read through a region window are filtered by that region's 8-bit QDMA mask, independently of its DMA mask.
- R6: The DMA mask of region r is at 0x0300 + 4·r (32 bits). The QDMA mask of region r is at 0x0380 + 4·r (low 8 bits, upper bits read 0). Both are read/write, unfiltered.
- R7: Set and clear registers act on write-1 bits only. Their 0 bits have no effect, and reading them returns 0.
- R8: `hw_evt` bits set event bits, and `xfer_done` bits set pending bits. A software clear of the same bit in the same cycle loses.
- R9: Any write to the evaluate register in the global window drives `eval_pulse` high for exactly the following cycle, and only if some pending bit has its interrupt-enable bit set. The evaluate offset is unmapped in region windows, and it reads 0.
- R10: Unmapped addresses read 0 and ignore writes. This covers unused offsets, offsets past 0x94, misaligned addresses and region indices of 4 or more.
- R11: `irq_level` is the OR of pending AND interrupt-enable, registered one cycle after the state changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 14 | Byte address of the access |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| hw_evt | input | 32 | Hardware event pulses, one per DMA channel |
| xfer_done | input | 32 | Transfer-completion pulses, one per completion code |
| dma_event | output | 32 | Event register |
| dma_enable | output | 32 | Channel enable register |
| qdma_enable | output | 8 | QDMA channel enable register |
| irq_level | output | 1 | Registered OR of enabled pending bits |
| eval_pulse | output | 1 | One-cycle interrupt re-evaluate request |

## Verification
State errors surface quickly at the ports.
- A corrupted ownership mask shows as a wrong masked read value on the next region read, or as a channel vector changing one cycle after a region write that should have been dropped.
- A wrong decode shows as a nonzero read or a changed output vector after an access to an unmapped address.
- Errors in the set/clear priority or in the interrupt state appear on `dma_event`, `irq_level` or `eval_pulse` within one or two cycles of the stimulus.

// File: rtl/dmarf_pkg.sv
package dmarf_pkg;

  typedef enum logic [3:0] {
    SEL_NONE,
    SEL_EVT, SEL_EVT_CLR, SEL_EVT_SET,
    SEL_ENA, SEL_ENA_CLR, SEL_ENA_SET,
    SEL_IEN, SEL_IEN_CLR, SEL_IEN_SET,
    SEL_IPEND, SEL_ICLR, SEL_IEVAL,
    SEL_QENA, SEL_QENA_CLR, SEL_QENA_SET
  } reg_sel_e;

  // last byte offset that belongs to a register window
  localparam logic [7:0] WIN_LAST = 8'h94;

  function automatic reg_sel_e offset_to_sel(input logic [7:0] off);
    case (off)
      8'h00:   return SEL_EVT;
      8'h08:   return SEL_EVT_CLR;
      8'h10:   return SEL_EVT_SET;
      8'h20:   return SEL_ENA;
      8'h28:   return SEL_ENA_CLR;
      8'h30:   return SEL_ENA_SET;
      8'h50:   return SEL_IEN;
      8'h58:   return SEL_IEN_CLR;
      8'h60:   return SEL_IEN_SET;
      8'h68:   return SEL_IPEND;
      8'h70:   return SEL_ICLR;
      8'h78:   return SEL_IEVAL;
      8'h84:   return SEL_QENA;
      8'h88:   return SEL_QENA_CLR;
      8'h8C:   return SEL_QENA_SET;
      default: return SEL_NONE;
    endcase
  endfunction

endpackage

// File: rtl/dmarf_decode.sv
module dmarf_decode
  import dmarf_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int NUM_REGIONS = 4,
  parameter int STRIDE_LG   = 9,
  parameter int GLOBAL_BASE = 'h1000,
  parameter int REGION_BASE = 'h2000,
  parameter int MASK_BASE   = 'h0300,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit_global,
  output logic              hit_region,
  output logic              hit_mask,
  output logic              mask_is_q,
  output logic [RIDX_W-1:0] region_idx,
  output logic [RIDX_W-1:0] mask_idx,
  output reg_sel_e          sel
);

  localparam int PAGE_W = ADDR_W - STRIDE_LG;
  localparam logic [ADDR_W-1:0] G_BASE = ADDR_W'(GLOBAL_BASE);
  localparam logic [ADDR_W-1:0] R_BASE = ADDR_W'(REGION_BASE);
  localparam logic [ADDR_W-1:0] M_BASE = ADDR_W'(MASK_BASE);
  // two mask banks of 0x80 bytes each: DMA then QDMA
  localparam logic [ADDR_W-1:0] M_SPAN = ADDR_W'('h100);

  logic [ADDR_W-1:0]    g_rel, r_rel, m_rel;
  logic [PAGE_W-1:0]    r_page;
  logic [STRIDE_LG-1:0] r_off;
  logic                 in_g, in_r, in_m;
  reg_sel_e             g_sel, r_sel;

  always_comb begin
    g_rel  = addr - G_BASE;
    r_rel  = addr - R_BASE;
    m_rel  = addr - M_BASE;
    r_page = r_rel[ADDR_W-1:STRIDE_LG];
    r_off  = r_rel[STRIDE_LG-1:0];

    in_g = (addr >= G_BASE) && (g_rel <= ADDR_W'(WIN_LAST));
    in_r = (addr >= R_BASE) && (r_page < PAGE_W'(NUM_REGIONS))
           && (r_off <= STRIDE_LG'(WIN_LAST));
    in_m = (addr >= M_BASE) && (m_rel < M_SPAN) && (m_rel[1:0] == 2'b00)
           && (m_rel[6:2] < 5'(NUM_REGIONS));

    g_sel = in_g ? offset_to_sel(g_rel[7:0]) : SEL_NONE;
    r_sel = in_r ? offset_to_sel(r_off[7:0]) : SEL_NONE;
    // the evaluate register exists in the global window only
    if (r_sel == SEL_IEVAL) r_sel = SEL_NONE;

    hit_global = (g_sel != SEL_NONE);
    hit_region = (r_sel != SEL_NONE);
    hit_mask   = in_m;
    mask_is_q  = m_rel[7];
    mask_idx   = m_rel[2 +: RIDX_W];
    region_idx = r_page[RIDX_W-1:0];
    sel        = hit_global ? g_sel : r_sel;
  end

  // R10: at most one target may claim an address
  always_comb begin
    p_one_window_r10: assert ($onehot0({hit_global, hit_region, hit_mask}))
      else $error("decode claimed by more than one target");
  end

endmodule

// File: rtl/dmarf_mask_bank.sv
module dmarf_mask_bank #(
  parameter int NUM_REGIONS = 4,
  parameter int NUM_DMA     = 32,
  parameter int NUM_QDMA    = 8,
  parameter int DATA_W      = 32,
  localparam int RIDX_W     = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                acc_is_q,
  input  logic [RIDX_W-1:0]   acc_idx,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [RIDX_W-1:0]   cur_idx,
  output logic [NUM_DMA-1:0]  cur_dma,
  output logic [NUM_QDMA-1:0] cur_qdma,
  output logic [DATA_W-1:0]   rd_data
);

  logic [NUM_REGIONS*NUM_DMA-1:0]  dma_flat;
  logic [NUM_REGIONS*NUM_QDMA-1:0] qdma_flat;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_region
    logic [NUM_DMA-1:0]  dm;
    logic [NUM_QDMA-1:0] qm;

    always_ff @(posedge clk) begin
      if (rst) begin
        dm <= '0;
        qm <= '0;
      end else if (wr_en && acc_idx == RIDX_W'(r)) begin
        if (acc_is_q) qm <= wdata[NUM_QDMA-1:0];
        else          dm <= wdata[NUM_DMA-1:0];
      end
    end

    assign dma_flat[r*NUM_DMA +: NUM_DMA]    = dm;
    assign qdma_flat[r*NUM_QDMA +: NUM_QDMA] = qm;

    p_mask_load_r6: assert property (@(posedge clk) disable iff (rst)
      (wr_en && !acc_is_q && acc_idx == RIDX_W'(r)) |=> dm == $past(wdata[NUM_DMA-1:0]))
      else $error("DMA mask write lost");
  end

  always_comb begin
    cur_dma  = dma_flat[cur_idx*NUM_DMA +: NUM_DMA];
    cur_qdma = qdma_flat[cur_idx*NUM_QDMA +: NUM_QDMA];
    if (acc_is_q) rd_data = DATA_W'(qdma_flat[acc_idx*NUM_QDMA +: NUM_QDMA]);
    else          rd_data = DATA_W'(dma_flat[acc_idx*NUM_DMA +: NUM_DMA]);
  end

endmodule

// File: rtl/dmarf_chan_regs.sv
module dmarf_chan_regs #(
  parameter int NUM_DMA  = 32,
  parameter int NUM_QDMA = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_DMA-1:0]  evt_set,
  input  logic [NUM_DMA-1:0]  evt_clr,
  input  logic [NUM_DMA-1:0]  ena_set,
  input  logic [NUM_DMA-1:0]  ena_clr,
  input  logic [NUM_DMA-1:0]  ien_set,
  input  logic [NUM_DMA-1:0]  ien_clr,
  input  logic [NUM_DMA-1:0]  ipend_clr,
  input  logic [NUM_QDMA-1:0] qena_set,
  input  logic [NUM_QDMA-1:0] qena_clr,
  input  logic [NUM_DMA-1:0]  hw_evt,
  input  logic [NUM_DMA-1:0]  xfer_done,
  output logic [NUM_DMA-1:0]  evt,
  output logic [NUM_DMA-1:0]  ena,
  output logic [NUM_DMA-1:0]  ien,
  output logic [NUM_DMA-1:0]  ipend,
  output logic [NUM_QDMA-1:0] qena
);

  // hardware sets are applied after software clears, so they win
  always_ff @(posedge clk) begin
    if (rst) begin
      evt   <= '0;
      ena   <= '0;
      ien   <= '0;
      ipend <= '0;
      qena  <= '0;
    end else begin
      evt   <= (evt & ~evt_clr) | evt_set | hw_evt;
      ena   <= (ena & ~ena_clr) | ena_set;
      ien   <= (ien & ~ien_clr) | ien_set;
      ipend <= (ipend & ~ipend_clr) | xfer_done;
      qena  <= (qena & ~qena_clr) | qena_set;
    end
  end

  p_hw_evt_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (hw_evt != '0) |=> ((evt & $past(hw_evt)) == $past(hw_evt)))
    else $error("hardware event bit not set");

  p_done_wins_r8: assert property (@(posedge clk) disable iff (rst)
    (xfer_done != '0) |=> ((ipend & $past(xfer_done)) == $past(xfer_done)))
    else $error("completion bit not pending");

  p_evt_clear_r7: assert property (@(posedge clk) disable iff (rst)
    ((evt_clr & ~hw_evt & ~evt_set) != '0)
      |=> ((evt & $past(evt_clr & ~hw_evt & ~evt_set)) == '0))
    else $error("event clear had no effect");

endmodule

// File: rtl/dma_region_filter.sv
module dma_region_filter
  import dmarf_pkg::*;
#(
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 32,
  parameter int NUM_DMA     = 32,
  parameter int NUM_QDMA    = 8,
  parameter int NUM_REGIONS = 4,
  parameter int STRIDE_LG   = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                wr_en,
  input  logic                rd_en,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_DMA-1:0]  hw_evt,
  input  logic [NUM_DMA-1:0]  xfer_done,
  output logic [NUM_DMA-1:0]  dma_event,
  output logic [NUM_DMA-1:0]  dma_enable,
  output logic [NUM_QDMA-1:0] qdma_enable,
  output logic                irq_level,
  output logic                eval_pulse
);

  localparam int RIDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;

  logic              hit_global, hit_region, hit_mask, mask_is_q;
  logic [RIDX_W-1:0] region_idx, mask_idx;
  reg_sel_e          sel;

  dmarf_decode #(
    .ADDR_W(ADDR_W), .NUM_REGIONS(NUM_REGIONS), .STRIDE_LG(STRIDE_LG)
  ) u_decode (
    .addr(addr), .hit_global(hit_global), .hit_region(hit_region),
    .hit_mask(hit_mask), .mask_is_q(mask_is_q), .region_idx(region_idx),
    .mask_idx(mask_idx), .sel(sel)
  );

  logic [NUM_DMA-1:0]  cur_dma;
  logic [NUM_QDMA-1:0] cur_qdma;
  logic [DATA_W-1:0]   mask_rd;

  dmarf_mask_bank #(
    .NUM_REGIONS(NUM_REGIONS), .NUM_DMA(NUM_DMA), .NUM_QDMA(NUM_QDMA), .DATA_W(DATA_W)
  ) u_masks (
    .clk(clk), .rst(rst), .wr_en(wr_en && hit_mask), .acc_is_q(mask_is_q),
    .acc_idx(mask_idx), .wdata(wdata), .cur_idx(region_idx),
    .cur_dma(cur_dma), .cur_qdma(cur_qdma), .rd_data(mask_rd)
  );

  // ownership filter: all-ones for the global window
  logic [NUM_DMA-1:0]  own_d, wbits_d;
  logic [NUM_QDMA-1:0] own_q, wbits_q;
  logic                wr_win;

  logic [NUM_DMA-1:0]  evt_set, evt_clr, ena_set, ena_clr;
  logic [NUM_DMA-1:0]  ien_set, ien_clr, ipend_clr;
  logic [NUM_QDMA-1:0] qena_set, qena_clr;
  logic [NUM_DMA-1:0]  evt, ena, ien, ipend;
  logic [NUM_QDMA-1:0] qena;

  always_comb begin
    own_d   = hit_region ? cur_dma  : '1;
    own_q   = hit_region ? cur_qdma : '1;
    wbits_d = wdata[NUM_DMA-1:0]  & own_d;
    wbits_q = wdata[NUM_QDMA-1:0] & own_q;
    wr_win  = wr_en && (hit_global || hit_region);

    evt_set   = (wr_win && sel == SEL_EVT_SET)  ? wbits_d : '0;
    evt_clr   = (wr_win && sel == SEL_EVT_CLR)  ? wbits_d : '0;
    ena_set   = (wr_win && sel == SEL_ENA_SET)  ? wbits_d : '0;
    ena_clr   = (wr_win && sel == SEL_ENA_CLR)  ? wbits_d : '0;
    ien_set   = (wr_win && sel == SEL_IEN_SET)  ? wbits_d : '0;
    ien_clr   = (wr_win && sel == SEL_IEN_CLR)  ? wbits_d : '0;
    ipend_clr = (wr_win && sel == SEL_ICLR)     ? wbits_d : '0;
    qena_set  = (wr_win && sel == SEL_QENA_SET) ? wbits_q : '0;
    qena_clr  = (wr_win && sel == SEL_QENA_CLR) ? wbits_q : '0;
  end

  dmarf_chan_regs #(.NUM_DMA(NUM_DMA), .NUM_QDMA(NUM_QDMA)) u_regs (
    .clk(clk), .rst(rst),
    .evt_set(evt_set), .evt_clr(evt_clr), .ena_set(ena_set), .ena_clr(ena_clr),
    .ien_set(ien_set), .ien_clr(ien_clr), .ipend_clr(ipend_clr),
    .qena_set(qena_set), .qena_clr(qena_clr),
    .hw_evt(hw_evt), .xfer_done(xfer_done),
    .evt(evt), .ena(ena), .ien(ien), .ipend(ipend), .qena(qena)
  );

  // read path; set/clear/evaluate registers read as zero
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    rd_val = '0;
    if (hit_mask) begin
      rd_val = mask_rd;
    end else begin
      case (sel)
        SEL_EVT:   rd_val = DATA_W'(evt   & own_d);
        SEL_ENA:   rd_val = DATA_W'(ena   & own_d);
        SEL_IEN:   rd_val = DATA_W'(ien   & own_d);
        SEL_IPEND: rd_val = DATA_W'(ipend & own_d);
        SEL_QENA:  rd_val = DATA_W'(qena  & own_q);
        default:   rd_val = '0;
      endcase
    end
  end

  logic eval_wr, any_enabled;
  assign eval_wr     = wr_en && hit_global && (sel == SEL_IEVAL);
  assign any_enabled = |(ipend & ien);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata      <= '0;
      irq_level  <= 1'b0;
      eval_pulse <= 1'b0;
    end else begin
      rdata      <= rd_en ? rd_val : '0;
      irq_level  <= any_enabled;
      eval_pulse <= eval_wr && any_enabled;
    end
  end

  assign dma_event   = evt;
  assign dma_enable  = ena;
  assign qdma_enable = qena;

  p_region_write_owned_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_region)
      |-> (((evt_set | evt_clr | ena_set | ena_clr | ien_set | ien_clr | ipend_clr)
            & ~cur_dma) == '0))
    else $error("region write reached an unowned channel");

  p_region_qdma_owned_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && hit_region) |-> (((qena_set | qena_clr) & ~cur_qdma) == '0))
    else $error("region write reached an unowned QDMA channel");

  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> (rdata == '0))
    else $error("read data not zero while idle");

  p_eval_global_r9: assert property (@(posedge clk) disable iff (rst)
    eval_pulse |-> $past(wr_en && hit_global))
    else $error("evaluate pulse without a global write");

  p_irq_latency_r11: assert property (@(posedge clk) disable iff (rst)
    irq_level |-> $past(|(ipend & ien)))
    else $error("interrupt level without enabled pending bit");

endmodule

// File: tb/dma_region_filter_tb.sv
`timescale 1ns/1ps
module dma_region_filter_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [31:0] hw_evt = '0;
  logic [31:0] xfer_done = '0;
  logic [31:0] dma_event, dma_enable;
  logic [7:0]  qdma_enable;
  logic        irq_level, eval_pulse;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  dma_region_filter u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .hw_evt(hw_evt), .xfer_done(xfer_done), .dma_event(dma_event),
    .dma_enable(dma_enable), .qdma_enable(qdma_enable), .irq_level(irq_level),
    .eval_pulse(eval_pulse)
  );

  localparam logic [13:0] G = 14'h1000;
  function automatic logic [13:0] rg(input int r);
    return 14'(14'h2000 + 14'h200 * r);
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic wr_ev(input logic [13:0] a, input logic [31:0] d,
                       input logic [31:0] hw, input logic [31:0] dn);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1; hw_evt = hw; xfer_done = dn;
    @(negedge clk);
    wr_en = 1'b0; hw_evt = '0; xfer_done = '0;
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    wr_ev(a, d, '0, '0);
  endtask

  task automatic rd(input logic [13:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    chk("R1 event after reset", dma_event, 32'h0);
    chk("R1 enable after reset", dma_enable, 32'h0);
    chk("R1 qdma after reset", {24'h0, qdma_enable}, 32'h0);
    chk("R1 irq/eval after reset", {30'h0, irq_level, eval_pulse}, 32'h0);
    chk("R1 rdata after reset", rdata, 32'h0);
    rd(14'h0300, v);
    chk("R1 mask zero after reset", v, 32'h0);
  endtask

  task automatic t_global();
    logic [31:0] v;
    do_reset();
    wr(G + 14'h10, 32'hA5A5_0001);
    chk("R2 global event set", dma_event, 32'hA5A5_0001);
    rd(G + 14'h00, v);
    chk("R2 global event read", v, 32'hA5A5_0001);
    @(negedge clk);
    chk("R2 rdata zero when idle", rdata, 32'h0);
    wr(G + 14'h08, 32'h0000_0001);
    chk("R7 write-1 clear", dma_event, 32'hA5A5_0000);
    rd(G + 14'h10, v);
    chk("R7 set alias reads zero", v, 32'h0);
    rd(G + 14'h08, v);
    chk("R7 clear alias reads zero", v, 32'h0);
  endtask

  task automatic t_region_write();
    do_reset();
    wr(14'h0308, 32'h0000_FFFF);
    wr(rg(2) + 14'h30, 32'hFFFF_FFFF);
    chk("R3 region enable set filtered", dma_enable, 32'h0000_FFFF);
    wr(G + 14'h30, 32'hFFFF_0000);
    chk("R3 global enable set unfiltered", dma_enable, 32'hFFFF_FFFF);
    wr(rg(2) + 14'h28, 32'hFFFF_FFFF);
    chk("R3 region enable clear filtered", dma_enable, 32'hFFFF_0000);
    wr(rg(1) + 14'h10, 32'hFFFF_FFFF);
    chk("R3 unowned region write dropped", dma_event, 32'h0);
  endtask

  task automatic t_region_read();
    logic [31:0] v;
    do_reset();
    wr(G + 14'h10, 32'h1234_5678);
    wr(14'h030C, 32'h0000_0FF0);
    rd(rg(3) + 14'h00, v);
    chk("R4 region event read masked", v, 32'h0000_0670);
    rd(rg(0) + 14'h00, v);
    chk("R4 unowned region read zero", v, 32'h0);
    rd(G + 14'h00, v);
    chk("R4 global read unmasked", v, 32'h1234_5678);
    wr(G + 14'h60, 32'hF0F0_F0F0);
    rd(rg(3) + 14'h50, v);
    chk("R4 region int-enable read masked", v, 32'h0000_00F0);
  endtask

  task automatic t_qdma();
    logic [31:0] v;
    do_reset();
    wr(14'h0384, 32'h0000_000F);
    wr(rg(1) + 14'h8C, 32'h0000_00FF);
    chk("R5 region qdma set filtered", {24'h0, qdma_enable}, 32'h0F);
    wr(G + 14'h8C, 32'h0000_00F0);
    chk("R5 global qdma set", {24'h0, qdma_enable}, 32'hFF);
    rd(rg(1) + 14'h84, v);
    chk("R5 region qdma read masked", v, 32'h0F);
    wr(rg(1) + 14'h88, 32'h0000_00FF);
    chk("R5 region qdma clear filtered", {24'h0, qdma_enable}, 32'hF0);
    wr(rg(2) + 14'h8C, 32'h0000_00FF);
    chk("R5 qdma mask zero drops set", {24'h0, qdma_enable}, 32'hF0);
  endtask

  task automatic t_masks();
    logic [31:0] v;
    do_reset();
    wr(14'h0300, 32'hDEAD_BEEF);
    rd(14'h0300, v);
    chk("R6 DMA mask readback", v, 32'hDEAD_BEEF);
    wr(14'h038C, 32'h0000_01FF);
    rd(14'h038C, v);
    chk("R6 QDMA mask 8 bits", v, 32'h0000_00FF);
    wr(14'h0310, 32'hFFFF_FFFF);
    rd(14'h0310, v);
    chk("R10 no fifth region mask", v, 32'h0);
  endtask

  task automatic t_hw();
    logic [31:0] v;
    do_reset();
    wr(G + 14'h10, 32'h0000_0003);
    wr_ev(G + 14'h08, 32'h0000_0003, 32'h0000_0001, 32'h0);
    chk("R8 hw event beats clear", dma_event, 32'h0000_0001);
    wr_ev(G + 14'h20, 32'h0, 32'h0000_0100, 32'h0000_0004);
    chk("R8 hw event pulse sets", dma_event, 32'h0000_0101);
    wr_ev(G + 14'h70, 32'h0000_0004, 32'h0, 32'h0000_0004);
    rd(G + 14'h68, v);
    chk("R8 completion beats pending clear", v, 32'h0000_0004);
  endtask

  task automatic t_eval();
    logic [31:0] v;
    do_reset();
    wr_ev(G + 14'h20, 32'h0, 32'h0, 32'h0000_0100);
    wr(G + 14'h78, 32'h1);
    chk("R9 no pulse without enabled pending", {31'h0, eval_pulse}, 32'h0);
    wr(G + 14'h60, 32'h0000_0100);
    chk("R11 irq one cycle after enable", {31'h0, irq_level}, 32'h0);
    @(negedge clk);
    chk("R11 irq raised", {31'h0, irq_level}, 32'h1);
    wr(G + 14'h78, 32'h0);
    chk("R9 evaluate pulse", {31'h0, eval_pulse}, 32'h1);
    @(negedge clk);
    chk("R9 pulse lasts one cycle", {31'h0, eval_pulse}, 32'h0);
    wr(14'h0300, 32'hFFFF_FFFF);
    wr(rg(0) + 14'h78, 32'h1);
    chk("R9 region evaluate ignored", {31'h0, eval_pulse}, 32'h0);
    rd(G + 14'h78, v);
    chk("R9 evaluate reads zero", v, 32'h0);
  endtask

  task automatic t_decode();
    logic [31:0] v;
    do_reset();
    wr(G + 14'h10, 32'h0000_0010);
    wr(14'h2800 + 14'h10, 32'hFFFF_FFFF);
    chk("R10 region 4 write ignored", dma_event, 32'h0000_0010);
    rd(14'h2800, v);
    chk("R10 region 4 read zero", v, 32'h0);
    wr(G + 14'h04, 32'hFFFF_FFFF);
    rd(G + 14'h04, v);
    chk("R10 unused offset reads zero", v, 32'h0);
    wr(G + 14'h12, 32'hFFFF_FFFF);
    chk("R10 misaligned write ignored", dma_event, 32'h0000_0010);
    rd(G + 14'h98, v);
    chk("R10 past window reads zero", v, 32'h0);
  endtask

  initial begin
    t_reset();
    t_global();
    t_region_write();
    t_region_read();
    t_qdma();
    t_masks();
    t_hw();
    t_eval();
    t_decode();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule